// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus with an open-drain data line. It holds the configuration of a clock synthesizer's dividers: a reference divide code, a feedback divide code, a bypass flag for the reference divider, and a flag that selects the serially written codes over the pin-strapped ones. A system clock oversamples both bus lines, and the block drives the data line low only through `sda_oe`, which the pad turns into an open-drain pull-down.

A write begins with a start condition and the device address. Two filler bytes follow the address and are thrown away. The next three bytes land in three storage bytes. The first storage byte carries the two flags and the reference code, and the second carries the feedback code. The third storage byte is kept but drives nothing. Every byte after the third is acknowledged and dropped. A read returns the three storage bytes in order.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset every configuration output is zero, all three storage bytes are zero, and `sda_oe` is low.
- R2: A transfer begins only at a start condition, which is data falling while the clock is high. Clock pulses and data sent without a prior start get no acknowledge and change nothing. A stop condition is data rising while the clock is high, and it returns the block to idle.
- R3: The first byte after a start is the 7-bit address 1100101 sent MSB first, followed by a direction bit (0 = write, 1 = read). On a match the slave holds data low during the ninth clock pulse.
- R4: If the address does not match, no acknowledge is given and no byte that follows is stored, until the next start.
- R5: In a write, the two bytes that follow the address are acknowledged and discarded.
- R6: The first stored byte sets `q_bypass` from bit 7, `reg_sel` from bit 6 and `q_code` from bits 5..0.
- R7: The second stored byte sets `p_code` from bits 7..0.
- R8: The third stored byte changes no output. Bytes after the third are acknowledged but not stored.
- R9: In a read, the slave sends storage bytes 1, 2, 3, MSB first, and then 0x00. Each byte continues while the master acknowledges it. After a master not-acknowledge the slave releases the line.
- R10: A repeated start at any point restarts address reception, and the filler count starts again.
- R11: A byte cut short by a stop is not stored. Bytes already completed in that transfer are kept.
- R12: `sda_oe` and the configuration outputs change only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| q_bypass | output | 1 | Reference divider bypass flag |
| reg_sel | output | 1 | Selects the serially written codes |
| q_code | output | 6 | Reference divider code |
| p_code | output | 8 | Feedback divider code |

## Verification
The hardest cases to reach are the byte counter's positions relative to bus events: a repeated start that arrives while a filler is being consumed, and a stop that cuts a data byte short after its first bits. Directed transfers build these framings bit by bit with a modelled open-drain line, and then read the storage bytes back over the bus. Seeded random transfers vary the address, the byte count and the direction on top of that, and a reference model of the three storage bytes checks every acknowledge, every read byte and every output.

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1100101,
  parameter int         DUMMY_BYTES = 2,
  parameter int         REG_BYTES   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       q_bypass,
  output logic       reg_sel,
  output logic [5:0] q_code,
  output logic [7:0] p_code
);
  localparam int IW = $clog2(DUMMY_BYTES + REG_BYTES + 1);
  localparam int RW = $clog2(REG_BYTES + 1);
  localparam int AW = $clog2(REG_BYTES);
  localparam logic [IW-1:0] FIRST_REG = IW'(DUMMY_BYTES);
  localparam logic [IW-1:0] LAST_IDX  = IW'(DUMMY_BYTES + REG_BYTES);
  localparam logic [RW-1:0] NREG      = RW'(REG_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_c, stop_c;

  st_t                     st;
  logic [3:0]              bitcnt;
  logic [7:0]              shreg, txsh;
  logic                    addr_ph, rd_mode, nack;
  logic [IW-1:0]           idx, rel;
  logic [RW-1:0]           rd_ptr;
  logic [REG_BYTES-1:0][7:0] regs;
  logic [7:0]              rd_byte;
  logic [AW-1:0]           wr_ix;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  assign rel     = idx - FIRST_REG;
  assign wr_ix   = AW'(rel);
  assign rd_byte = (rd_ptr < NREG) ? regs[AW'(rd_ptr)] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; txsh <= '0;
      addr_ph <= 1'b0; rd_mode <= 1'b0; nack <= 1'b0;
      idx <= '0; rd_ptr <= '0; regs <= '0;
    end else if (start_c) begin
      st <= S_RX; bitcnt <= '0; addr_ph <= 1'b1;
      idx <= '0; rd_ptr <= '0;
    end else if (stop_c) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_RX:
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (addr_ph) begin
              addr_ph <= 1'b0;
              if (shreg[7:1] == DEV_ADDR) begin
                st      <= S_ACK;
                rd_mode <= shreg[0];
              end else begin
                st <= S_IDLE;
              end
            end else begin
              st <= S_ACK;
              if (idx >= FIRST_REG && idx < LAST_IDX) regs[wr_ix] <= shreg;
              if (idx < LAST_IDX) idx <= idx + IW'(1);
            end
          end
        S_ACK:
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              st   <= S_TX;
              txsh <= rd_byte;
              if (rd_ptr < NREG) rd_ptr <= rd_ptr + RW'(1);
            end else begin
              st <= S_RX;
            end
          end
        S_TX:
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              st     <= S_RACK;
              bitcnt <= '0;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        S_RACK:
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              st <= S_IDLE;
            end else begin
              st   <= S_TX;
              txsh <= rd_byte;
              if (rd_ptr < NREG) rd_ptr <= rd_ptr + RW'(1);
            end
          end
        default: ;
      endcase
    end

  assign sda_oe   = (st == S_ACK) | ((st == S_TX) & ~txsh[7]);
  assign q_bypass = regs[0][7];
  assign reg_sel  = regs[0][6];
  assign q_code   = regs[0][5:0];
  assign p_code   = regs[1];
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       q_bypass,
  input logic       reg_sel,
  input logic [5:0] q_code,
  input logic [7:0] p_code
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sda_oe && !q_bypass && !reg_sel && q_code == 6'd0 && p_code == 8'd0));

  // R12
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R12
  oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);

  // R12
  cfg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({q_bypass, reg_sel, q_code, p_code}) |-> !scl_i);
endmodule

bind cfg_serial_slave cfg_serial_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .q_bypass(q_bypass), .reg_sel(reg_sel), .q_code(q_code), .p_code(p_code)
);

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb;
  localparam logic [6:0] ADDR = 7'b1100101;
  localparam int H = 16;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, q_bypass, reg_sel;
  logic [5:0] q_code;
  logic [7:0] p_code;
  logic sda_line;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_r [3];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  cfg_serial_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .q_bypass(q_bypass), .reg_sel(reg_sel), .q_code(q_code), .p_code(p_code)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    wt(Q); sda_m = b; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_line; wt(Q); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(~m_ack);
  endtask

  task automatic chk_out(input string req);
    chk(req, {24'd0, q_bypass, reg_sel, q_code}, {24'd0, exp_r[0]});
    chk(req, {24'd0, p_code}, {24'd0, exp_r[1]});
  endtask

  // Full write: address, then n bytes; acks compared with model
  task automatic wr_txn(input logic [6:0] a, input int n, input logic [7:0][7:0] d, input string req);
    logic ok;
    logic [8:0] got, exp;
    logic match;
    match = (a == ADDR);
    got = '0; exp = '0;
    bus_start();
    send_byte({a, 1'b0}, ok);
    got[0] = ok; exp[0] = match;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ok);
      got[i+1] = ok; exp[i+1] = match;
      if (match && i >= 2 && i < 5) exp_r[i-2] = d[i];
    end
    bus_stop();
    chk({req, " ack"}, {23'd0, got}, {23'd0, exp});
    chk_out(req);
  endtask

  task automatic rd_txn(input int n, input string req);
    logic ok;
    logic [7:0] b;
    bus_start();
    send_byte({ADDR, 1'b1}, ok);
    chk({req, " addr ack"}, {31'd0, ok}, 32'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(req, {24'd0, b}, {24'd0, (i < 3) ? exp_r[i] : 8'h00});
    end
    bus_stop();
    chk({req, " release"}, {31'd0, sda_oe}, 32'd0);
  endtask

  initial begin
    wt(190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic ok;
    logic [7:0][7:0] d;
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 3; i++) exp_r[i] = 8'h00;
    wt(5); rst_n = 1'b1; wt(5);

    // R1 reset state
    chk("R1 oe", {31'd0, sda_oe}, 32'd0);
    chk_out("R1");

    // R2 a matching address clocked in with no start gets no ack
    for (int i = 7; i >= 0; i--) bit_out(i == 0 ? 1'b0 : ADDR[i-1]);
    bit_in(a);
    chk("R2 no start", {31'd0, a}, 32'd1);
    bus_stop();
    chk_out("R2");

    // R3 R5 R6 R7 basic write with distinct fillers
    d = '0; d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'hC5; d[3] = 8'h9A;
    wr_txn(ADDR, 4, d, "R3 R5");
    chk("R6 bypass", {31'd0, q_bypass}, 32'd1);
    chk("R6 sel", {31'd0, reg_sel}, 32'd1);
    chk("R6 qcode", {26'd0, q_code}, 32'd5);
    chk("R7 pcode", {24'd0, p_code}, 32'h9A);

    // R4 wrong address
    d = {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    wr_txn(7'b1100100, 6, d, "R4");

    // R8 third byte plus extras
    d = '0; d[2] = 8'h3A; d[3] = 8'h5C; d[4] = 8'hE7; d[5] = 8'hFF; d[6] = 8'h81;
    wr_txn(ADDR, 7, d, "R8");
    // R9 readback past the end
    rd_txn(5, "R9 R8 read");

    // R10 repeated start during a filler
    bus_start();
    send_byte({ADDR, 1'b0}, ok);
    send_byte(8'hAA, ok);
    bus_start();
    send_byte({ADDR, 1'b0}, ok);
    send_byte(8'h00, ok);
    send_byte(8'h00, ok);
    send_byte(8'h3F, ok);
    chk("R10 ack", {31'd0, ok}, 32'd1);
    bus_stop();
    exp_r[0] = 8'h3F;
    chk_out("R10");

    // R11 stop in the middle of the second data byte
    bus_start();
    send_byte({ADDR, 1'b0}, ok);
    send_byte(8'h00, ok);
    send_byte(8'h00, ok);
    send_byte(8'h40, ok);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    exp_r[0] = 8'h40;
    chk_out("R11");
    rd_txn(3, "R11 read");

    // random mix
    for (int t = 0; t < 18; t++) begin
      logic [6:0] ra;
      int n;
      if ($urandom % 4 == 0) begin
        rd_txn(1 + int'($urandom % 4), "R9 rand");
      end else begin
        ra = ($urandom % 4 == 0) ? 7'($urandom) : ADDR;
        n = int'($urandom % 7);
        for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
        wr_txn(ra, n, d, "R4 R5 R8 rand");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule